// File: doc/BRIEF.md
# Receive-occupancy RTS flow controller with hysteresis

This block turns the fill level of a receive FIFO into an active-low request-to-send line. A 2-bit selector picks one of four programmed trigger levels. When automatic control is on, an interrupt is raised once the fill level reaches the selected trigger. The RTS line is released (driven high) at the next level up in the table, so the remote sender stops. It is only asserted again (driven low) once the fill level drops under the next level down.

The gap between the release point and the resume point keeps the RTS line from toggling each time one byte arrives or leaves near a single threshold. When automatic control is off, the line simply follows a software-driven RTS value. The FIFO and the serial datapath sit outside this block; it only sees the occupancy count.

All outputs are registered. Each output reflects the inputs present at the previous rising clock edge.

Top module: `rhc_auto_rts`

## Requirements
- R1: While and directly after synchronous reset, rts_n is 1 and rx_trig_irq is 0.
- R2: trig_sel values 0, 1, 2 and 3 select the trigger levels LVL0, LVL1, LVL2 and LVL3. The defaults are 8, 16, 56 and 60 with DEPTH 128.
- R3: With rts_auto_en at 1 and rx_count at or above the selected trigger, rx_trig_irq is 1 on the next cycle.
- R4: With rx_count below the selected trigger, or rts_auto_en at 0, rx_trig_irq is 0 on the next cycle.
- R5: With rts_auto_en at 1, rts_n goes to 1 on the next cycle once rx_count reaches the next higher table level. For trig_sel 3 that level is DEPTH.
- R6: With rts_auto_en at 1, rts_n goes to 0 on the next cycle once rx_count is below the next lower table level. For trig_sel 0 this happens only when rx_count is 0.
- R7: With rts_auto_en at 1 and rx_count between the resume and release levels, rts_n keeps its previous automatic value.
- R8: With rts_auto_en at 0, rts_n equals the previous cycle's sw_rts_n, and the hysteresis state is cleared. After re-enabling, rts_n is 0 until the release level is reached.
- R9: A change of trig_sel moves the trigger, release and resume levels on the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rts_auto_en | input | 1 | Enables automatic RTS control and the interrupt |
| trig_sel | input | 2 | Trigger-level selector |
| rx_count | input | CNT_W | Receive FIFO occupancy, 0 to DEPTH |
| sw_rts_n | input | 1 | Software RTS value used while automatic control is off |
| rts_n | output | 1 | Active-low request to send |
| rx_trig_irq | output | 1 | Receive trigger interrupt |

## Verification
The only hidden state is the one-bit hysteresis flag. If it is wrong, rts_n shows the wrong value on the first cycle the occupancy sits between the resume and release levels. An error in the level table shows as an interrupt or RTS edge that is one cycle early or late relative to a count crossing, so each sample is checked one clock after its inputs were applied. Random occupancy walks that repeatedly cross every level in both directions, under all four selector values, expose both kinds of error within a few crossings.

// File: rtl/rhc_pkg.sv
package rhc_pkg;

    typedef struct packed {
        logic [31:0] trig;
        logic [31:0] upper;
        logic [31:0] resume;
    } levels_t;

    function automatic logic at_or_above(input logic [31:0] cnt, input logic [31:0] lvl);
        return cnt >= lvl;
    endfunction

endpackage

// File: rtl/rhc_level_map.sv
module rhc_level_map
    import rhc_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned LVL0  = 8,
    parameter int unsigned LVL1  = 16,
    parameter int unsigned LVL2  = 56,
    parameter int unsigned LVL3  = 60
) (
    input  logic [1:0] sel,
    output levels_t    lv
);
    always_comb begin
        unique case (sel)
            2'd0:    lv = '{trig: 32'(LVL0), upper: 32'(LVL1),  resume: 32'd1};
            2'd1:    lv = '{trig: 32'(LVL1), upper: 32'(LVL2),  resume: 32'(LVL0)};
            2'd2:    lv = '{trig: 32'(LVL2), upper: 32'(LVL3),  resume: 32'(LVL1)};
            default: lv = '{trig: 32'(LVL3), upper: 32'(DEPTH), resume: 32'(LVL2)};
        endcase
    end
endmodule

// File: rtl/rhc_halt_track.sv
module rhc_halt_track
    import rhc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [31:0] cnt,
    input  levels_t     lv,
    output logic        halt_nxt
);
    logic halted_q;

    always_comb begin
        if (!en)                           halt_nxt = 1'b0;
        else if (at_or_above(cnt, lv.upper)) halt_nxt = 1'b1;
        else if (!at_or_above(cnt, lv.resume)) halt_nxt = 1'b0;
        else                               halt_nxt = halted_q;
    end

    always_ff @(posedge clk) begin
        if (rst) halted_q <= 1'b0;
        else     halted_q <= halt_nxt;
    end
endmodule

// File: rtl/rhc_out_stage.sv
module rhc_out_stage
    import rhc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        sw_rts_n,
    input  logic        halt_nxt,
    input  logic [31:0] cnt,
    input  levels_t     lv,
    output logic        rts_n,
    output logic        irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rts_n <= 1'b1;
            irq   <= 1'b0;
        end else begin
            rts_n <= en ? halt_nxt : sw_rts_n;
            irq   <= en && at_or_above(cnt, lv.trig);
        end
    end
endmodule

// File: rtl/rhc_auto_rts.sv
module rhc_auto_rts
    import rhc_pkg::*;
#(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned LVL0  = 8,
    parameter int unsigned LVL1  = 16,
    parameter int unsigned LVL2  = 56,
    parameter int unsigned LVL3  = 60,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rts_auto_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             sw_rts_n,
    output logic             rts_n,
    output logic             rx_trig_irq
);
    levels_t     lv;
    logic        halt_nxt;
    logic [31:0] cnt32;

    assign cnt32 = 32'(rx_count);

    rhc_level_map #(.DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)) u_map (
        .sel (trig_sel),
        .lv  (lv)
    );

    rhc_halt_track u_halt (
        .clk      (clk),
        .rst      (rst),
        .en       (rts_auto_en),
        .cnt      (cnt32),
        .lv       (lv),
        .halt_nxt (halt_nxt)
    );

    rhc_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .en       (rts_auto_en),
        .sw_rts_n (sw_rts_n),
        .halt_nxt (halt_nxt),
        .cnt      (cnt32),
        .lv       (lv),
        .rts_n    (rts_n),
        .irq      (rx_trig_irq)
    );
endmodule

// File: rtl/rhc_auto_rts_chk.sv
module rhc_auto_rts_chk #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned LVL0  = 8,
    parameter int unsigned LVL1  = 16,
    parameter int unsigned LVL2  = 56,
    parameter int unsigned LVL3  = 60,
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rts_auto_en,
    input logic [1:0]       trig_sel,
    input logic [CNT_W-1:0] rx_count,
    input logic             sw_rts_n,
    input logic             rts_n,
    input logic             rx_trig_irq
);
    int unsigned c_trig, c_hi, c_lo, c_cnt;

    always_comb begin
        c_cnt = 32'(rx_count);
        c_trig = (trig_sel == 2'd0) ? LVL0 : (trig_sel == 2'd1) ? LVL1 :
                 (trig_sel == 2'd2) ? LVL2 : LVL3;
        c_hi   = (trig_sel == 2'd0) ? LVL1 : (trig_sel == 2'd1) ? LVL2 :
                 (trig_sel == 2'd2) ? LVL3 : DEPTH;
        c_lo   = (trig_sel == 2'd0) ? 1 : (trig_sel == 2'd1) ? LVL0 :
                 (trig_sel == 2'd2) ? LVL1 : LVL2;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rts_n && !rx_trig_irq));

    p_irq_set_r3: assert property (@(posedge clk) disable iff (rst)
        (rts_auto_en && c_cnt >= c_trig) |=> rx_trig_irq);

    p_irq_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (!rts_auto_en || c_cnt < c_trig) |=> !rx_trig_irq);

    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        (rts_auto_en && c_cnt >= c_hi) |=> rts_n);

    p_resume_r6: assert property (@(posedge clk) disable iff (rst)
        (rts_auto_en && c_cnt < c_lo) |=> !rts_n);

    p_sw_follow_r8: assert property (@(posedge clk) disable iff (rst)
        !rts_auto_en |=> (rts_n == $past(sw_rts_n)));
endmodule

bind rhc_auto_rts rhc_auto_rts_chk #(
    .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .rts_auto_en(rts_auto_en), .trig_sel(trig_sel),
    .rx_count(rx_count), .sw_rts_n(sw_rts_n), .rts_n(rts_n), .rx_trig_irq(rx_trig_irq)
);

// File: tb/rhc_auto_rts_test.sv
module rhc_auto_rts_test;
    localparam int DEPTH = 128;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [1:0]    sel = 2'd0;
    logic [CW-1:0] cnt = '0;
    logic          sw = 1'b1;
    logic          rts_n, irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic m_halt = 1'b0, m_rts = 1'b1, m_irq = 1'b0;

    always #10 clk = ~clk;

    rhc_auto_rts uut (
        .clk(clk), .rst(rst), .rts_auto_en(en), .trig_sel(sel),
        .rx_count(cnt), .sw_rts_n(sw), .rts_n(rts_n), .rx_trig_irq(irq)
    );

    function automatic int f_trig(input logic [1:0] s);
        case (s) 2'd0: return 8; 2'd1: return 16; 2'd2: return 56; default: return 60; endcase
    endfunction
    function automatic int f_hi(input logic [1:0] s);
        return (s == 2'd3) ? DEPTH : f_trig(s + 2'd1);
    endfunction
    function automatic int f_lo(input logic [1:0] s);
        return (s == 2'd0) ? 1 : f_trig(s - 2'd1);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (sel=%0d cnt=%0d en=%b)", req, act, exp, sel, cnt, en);
        end
    endtask

    // one clock with current inputs; model updated, outputs checked at the falling edge
    task automatic step(input string tag);
        string rq_r, rq_i;
        int c = int'(cnt);
        @(posedge clk);
        if (rst) begin
            m_halt = 0; m_rts = 1; m_irq = 0; rq_r = "R1"; rq_i = "R1";
        end else if (!en) begin
            m_halt = 0; m_rts = sw; m_irq = 0; rq_r = "R8"; rq_i = "R4";
        end else begin
            if (c >= f_hi(sel)) begin m_halt = 1; rq_r = "R5"; end
            else if (c < f_lo(sel)) begin m_halt = 0; rq_r = "R6"; end
            else rq_r = "R7";
            m_rts = m_halt;
            m_irq = (c >= f_trig(sel));
            rq_i = m_irq ? "R3" : "R4";
        end
        @(negedge clk);
        chk({tag, rq_r}, rts_n, m_rts);
        chk({tag, rq_i}, irq, m_irq);
    endtask

    task automatic set_cnt(input int v);
        cnt = CW'(v);
        step("");
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        step("reset ");                      // R1
        rst = 0;
        step("after reset ");                // R1
        en = 1;
        // R2: ramp under each selector, irq must rise exactly at the table entry
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            for (int v = 0; v <= DEPTH; v += 4) set_cnt(v);
            for (int v = DEPTH; v >= 0; v -= 4) set_cnt(v);
        end
        sel = 2'd1;
        set_cnt(15); chk("R2 irq below 16", irq, 1'b0);
        set_cnt(16); chk("R2 irq at 16", irq, 1'b1);
        // R5/R6 boundary for sel 0: release at 16, resume only when empty
        sel = 2'd0;
        set_cnt(16); chk("R5 release sel0", rts_n, 1'b1);
        set_cnt(1);  chk("R7 hold at 1 sel0", rts_n, 1'b1);
        set_cnt(0);  chk("R6 resume at empty sel0", rts_n, 1'b0);
        // sel 3 releases only at DEPTH
        sel = 2'd3;
        set_cnt(DEPTH - 1); chk("R5 no release below full", rts_n, 1'b0);
        set_cnt(DEPTH);     chk("R5 release at full", rts_n, 1'b1);
        set_cnt(56);        chk("R7 hold at 56 sel3", rts_n, 1'b1);
        set_cnt(55);        chk("R6 resume at 55 sel3", rts_n, 1'b0);
        // R9: selector change moves levels next clock
        set_cnt(40); chk("R9 sel3 no irq at 40", irq, 1'b0);
        sel = 2'd1; step("R9 ");
        chk("R9 sel1 irq at 40", irq, 1'b1);
        // R8: disabled follows software bit, then re-enable starts released-clear
        sel = 2'd0; set_cnt(20);
        chk("R5 halted before disable", rts_n, 1'b1);
        en = 0; sw = 0; step("R8 ");
        chk("R8 sw 0", rts_n, 1'b0);
        sw = 1; step("R8 ");
        chk("R8 sw 1", rts_n, 1'b1);
        sel = 2'd1; en = 1; step("R8 ");
        chk("R8 reenable cleared", rts_n, 1'b0);
        // random walk
        for (int i = 0; i < 6000; i++) begin
            int v = int'(cnt) + int'($urandom_range(0, 8)) - 4;
            if (v < 0) v = 0;
            if (v > DEPTH) v = DEPTH;
            cnt = CW'(v);
            if ($urandom_range(0, 99) == 0) sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 49) == 0) en = ~en;
            sw = 1'($urandom_range(0, 1));
            step("rand ");
        end
        rst = 1; step("reset again ");
        chk("R1 rts after reset", rts_n, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule